// File: doc/BRIEF.md
# Run-Length Symbol Codec for a Parallel Peripheral Channel

This block turns a byte stream into tagged symbols and back again. On the send side, bytes arrive on a valid/ready stream. Each symbol leaves with a one-bit flag that marks it as data (flag high) or command (flag low). When compression is enabled, a run of equal bytes goes out as one count command followed by a single copy of the byte. A separate valid/ready input injects channel-address commands into the symbol stream.

On the receive side, tagged symbols come in on another valid/ready stream. A count command is held until the next data byte arrives, and that byte is then repeated. Address commands leave on their own output stream. The two sides share nothing but the clock and reset, so they can serve the two directions of a link or be chained back to back.

A command byte uses bit 7 to tell its two kinds apart. When bit 7 is 0, bits 6:0 hold a run count c, which stands for c+1 copies of the next data byte. When bit 7 is 1, bits 6:0 hold a channel address.

Top module: `rle_stream_codec`

## Requirements
- R1: While reset is held and on the first cycle after it, sym_valid, out_valid and chan_valid are low, and in_ready, addr_ready and rx_ready are high.
- R2: With cfg_rle_en low, every accepted byte is emitted in order as one symbol with sym_is_data=1 and the same byte value, including values with bit 7 set; no command symbols appear.
- R3: With cfg_rle_en high, a run of N equal bytes (2 <= N <= 128) inside one packet is emitted as a command symbol (sym_is_data=0, bit 7=0, bits 6:0 = N-1), and on the very next handshake the byte itself as a data symbol.
- R4: With cfg_rle_en high, a byte that differs from both its neighbours, or that stands alone in a packet, is emitted as a data symbol only, with no count in front.
- R5: A run longer than 128 bytes is cut into pieces of 128 copies from the start, and each piece is encoded by R3. A final piece of length 1 is encoded by R4.
- R6: A byte accepted with in_last high closes the run. The next packet starts a new run even when it begins with the same byte value.
- R7: An accepted address (addr_valid and addr_ready) first closes the open run, then emits a command symbol with bit 7 = 1 and bits 6:0 = addr_chan. While addr_valid is high, in_ready is low, so a byte offered in the same cycle is taken after the address.
- R8: While sym_valid is high and sym_ready is low, sym_valid, sym_byte and sym_is_data hold their values.
- R9: On the receive side, a count command c followed by a data byte b produces c+1 copies of b on out_byte. A data byte with no count before it produces one copy.
- R10: A received command with bit 7 = 1 presents bits 6:0 on chan_addr with chan_valid high and holds them until chan_ready. It also discards any pending count, so the next data byte is produced once.
- R11: rx_ready is low whenever out_valid is high and out_ready is low, so no new symbol is taken while an expansion is stalled.
- R12: While out_valid is high and out_ready is low, out_valid and out_byte hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rle_en | input | 1 | High: compress runs on the send side |
| in_valid | input | 1 | Source byte valid |
| in_ready | output | 1 | Source byte accepted this cycle when valid |
| in_byte | input | 8 | Source byte |
| in_last | input | 1 | Marks the last byte of a packet |
| addr_valid | input | 1 | Channel address to inject |
| addr_ready | output | 1 | Address accepted this cycle when valid |
| addr_chan | input | 7 | Channel address value |
| sym_valid | output | 1 | Outgoing symbol valid |
| sym_ready | input | 1 | Outgoing symbol accepted |
| sym_byte | output | 8 | Outgoing symbol byte |
| sym_is_data | output | 1 | 1 = data symbol, 0 = command symbol |
| rx_valid | input | 1 | Incoming symbol valid |
| rx_ready | output | 1 | Incoming symbol accepted this cycle when valid |
| rx_byte | input | 8 | Incoming symbol byte |
| rx_is_data | input | 1 | 1 = data symbol, 0 = command symbol |
| out_valid | output | 1 | Expanded byte valid |
| out_ready | input | 1 | Expanded byte accepted |
| out_byte | output | 8 | Expanded byte |
| chan_valid | output | 1 | Received channel address valid |
| chan_ready | input | 1 | Received channel address accepted |
| chan_addr | output | 7 | Received channel address |

## Verification
Two send-side events can fall in the same cycle: an address injection and a new source byte arriving while a run is still open. The bench offers both in one cycle and checks at the port that in_ready is low. It then checks that the symbol stream reads: the closed run, the address command, and only then the new byte. On the receive side, a stalled expansion and a waiting count can also coincide. This is provoked by holding out_ready low after a count and a data byte, and it is judged by rx_ready staying low and by the exact number of copies that appear once the stall is lifted.

// File: rtl/rle_codec_pkg.sv
`timescale 1ns/1ps
package rle_codec_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = BYTE_W - 1;

    // Run being collected on the send side
    typedef struct packed {
        logic              vld;
        logic              close;
        logic [BYTE_W-1:0] val;
        logic [CNT_W-1:0]  cnt;    // copies minus one
    } run_t;

    // Symbol slot: an optional count in front of one final symbol
    typedef struct packed {
        logic              cnt_pend;
        logic [BYTE_W-1:0] cnt_sym;
        logic              dat_pend;
        logic [BYTE_W-1:0] dat_sym;
        logic              dat_flag;  // 1 = data, 0 = command
    } slot_t;

    typedef struct packed {
        run_t  run;
        slot_t slot;
    } tx_state_t;

    typedef struct packed {
        logic [CNT_W-1:0]  pend_cnt;
        logic              out_vld;
        logic [BYTE_W-1:0] out_val;
        logic [CNT_W-1:0]  rem;
        logic              chan_vld;
        logic [CNT_W-1:0]  chan_val;
    } rx_state_t;

    function automatic slot_t slot_from_run(run_t r);
        slot_t s;
        s.cnt_pend = (r.cnt != '0);
        s.cnt_sym  = {1'b0, r.cnt};
        s.dat_pend = 1'b1;
        s.dat_sym  = r.val;
        s.dat_flag = 1'b1;
        return s;
    endfunction

    function automatic slot_t slot_raw(logic [BYTE_W-1:0] b);
        slot_t s;
        s.cnt_pend = 1'b0;
        s.cnt_sym  = '0;
        s.dat_pend = 1'b1;
        s.dat_sym  = b;
        s.dat_flag = 1'b1;
        return s;
    endfunction

    function automatic slot_t slot_addr(logic [CNT_W-1:0] a);
        slot_t s;
        s.cnt_pend = 1'b0;
        s.cnt_sym  = '0;
        s.dat_pend = 1'b1;
        s.dat_sym  = {1'b1, a};
        s.dat_flag = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/rle_tx_packer.sv
`timescale 1ns/1ps
module rle_tx_packer
    import rle_codec_pkg::*;
#(
    parameter int RUN_LIMIT = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rle_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    input  logic              addr_valid,
    output logic              addr_ready,
    input  logic [CNT_W-1:0]  addr_chan,
    output logic              sym_valid,
    input  logic              sym_ready,
    output logic [BYTE_W-1:0] sym_byte,
    output logic              sym_is_data
);

    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(RUN_LIMIT - 1);

    tx_state_t q, d;
    logic      slot_free;
    logic      take_addr;
    logic      take_byte;
    logic      same_run;

    // The slot can be refilled when empty or when its last symbol leaves now
    assign slot_free  = !q.slot.dat_pend || (sym_ready && !q.slot.cnt_pend);
    assign addr_ready = slot_free && !q.run.vld;
    assign in_ready   = slot_free && !q.run.close && (rle_en || !q.run.vld) && !addr_valid;
    assign take_addr  = addr_valid && addr_ready;
    assign take_byte  = in_valid && in_ready;
    assign same_run   = q.run.vld && (in_byte == q.run.val) && (q.run.cnt != CNT_LIM);

    assign sym_valid   = q.slot.dat_pend;
    assign sym_byte    = q.slot.cnt_pend ? q.slot.cnt_sym : q.slot.dat_sym;
    assign sym_is_data = q.slot.cnt_pend ? 1'b0 : q.slot.dat_flag;

    always_comb begin
        d = q;
        // Drain one symbol per handshake
        if (q.slot.dat_pend && sym_ready) begin
            if (q.slot.cnt_pend) d.slot.cnt_pend = 1'b0;
            else                 d.slot.dat_pend = 1'b0;
        end
        if (take_addr) begin
            d.slot = slot_addr(addr_chan);
        end else if (take_byte) begin
            if (!rle_en) begin
                d.slot = slot_raw(in_byte);
            end else if (!q.run.vld) begin
                d.run.vld   = 1'b1;
                d.run.close = in_last;
                d.run.val   = in_byte;
                d.run.cnt   = '0;
            end else if (same_run) begin
                d.run.cnt   = q.run.cnt + CNT_W'(1);
                d.run.close = in_last;
            end else begin
                d.slot      = slot_from_run(q.run);
                d.run.vld   = 1'b1;
                d.run.close = in_last;
                d.run.val   = in_byte;
                d.run.cnt   = '0;
            end
        end else if (slot_free && q.run.vld &&
                     (q.run.close || !rle_en || addr_valid)) begin
            d.slot = slot_from_run(q.run);
            d.run  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/rle_rx_expander.sv
`timescale 1ns/1ps
module rle_rx_expander
    import rle_codec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_is_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              chan_valid,
    input  logic              chan_ready,
    output logic [CNT_W-1:0]  chan_addr
);

    rx_state_t q, d;
    logic      out_free;
    logic      chan_free;
    logic      take;
    logic      is_addr;

    assign out_free  = !q.out_vld || (out_ready && q.rem == '0);
    assign chan_free = !q.chan_vld || chan_ready;
    assign rx_ready  = out_free && chan_free;
    assign take      = rx_valid && rx_ready;
    assign is_addr   = rx_byte[BYTE_W-1];

    assign out_valid  = q.out_vld;
    assign out_byte   = q.out_val;
    assign chan_valid = q.chan_vld;
    assign chan_addr  = q.chan_val;

    always_comb begin
        d = q;
        if (q.out_vld && out_ready) begin
            if (q.rem == '0) d.out_vld = 1'b0;
            else             d.rem     = q.rem - CNT_W'(1);
        end
        if (q.chan_vld && chan_ready) d.chan_vld = 1'b0;
        if (take) begin
            if (rx_is_data) begin
                d.out_vld  = 1'b1;
                d.out_val  = rx_byte;
                d.rem      = q.pend_cnt;
                d.pend_cnt = '0;
            end else if (is_addr) begin
                d.chan_vld = 1'b1;
                d.chan_val = rx_byte[CNT_W-1:0];
                d.pend_cnt = '0;
            end else begin
                d.pend_cnt = rx_byte[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/rle_stream_codec.sv
`timescale 1ns/1ps
module rle_stream_codec
    import rle_codec_pkg::*;
#(
    parameter int RUN_LIMIT = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rle_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    input  logic              addr_valid,
    output logic              addr_ready,
    input  logic [CNT_W-1:0]  addr_chan,
    output logic              sym_valid,
    input  logic              sym_ready,
    output logic [BYTE_W-1:0] sym_byte,
    output logic              sym_is_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_is_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              chan_valid,
    input  logic              chan_ready,
    output logic [CNT_W-1:0]  chan_addr
);

    rle_tx_packer #(.RUN_LIMIT(RUN_LIMIT)) packer_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rle_en      (cfg_rle_en),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_byte     (in_byte),
        .in_last     (in_last),
        .addr_valid  (addr_valid),
        .addr_ready  (addr_ready),
        .addr_chan   (addr_chan),
        .sym_valid   (sym_valid),
        .sym_ready   (sym_ready),
        .sym_byte    (sym_byte),
        .sym_is_data (sym_is_data)
    );

    rle_rx_expander expander_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_ready   (rx_ready),
        .rx_byte    (rx_byte),
        .rx_is_data (rx_is_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_byte   (out_byte),
        .chan_valid (chan_valid),
        .chan_ready (chan_ready),
        .chan_addr  (chan_addr)
    );

endmodule

// File: rtl/rle_stream_codec_chk.sv
`timescale 1ns/1ps
module rle_stream_codec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid,
    input logic       sym_ready,
    input logic [7:0] sym_byte,
    input logic       sym_is_data,
    input logic       rx_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       chan_valid,
    input logic       chan_ready,
    input logic [6:0] chan_addr
);

    // R8
    sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_byte) && $stable(sym_is_data)));

    // R3
    cnt_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready && !sym_is_data && !sym_byte[7]) |=> (sym_valid && sym_is_data));

    // R11
    expand_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !rx_ready);

    // R12
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    // R10
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_valid && !chan_ready) |=> (chan_valid && $stable(chan_addr)));

endmodule

bind rle_stream_codec rle_stream_codec_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid   (sym_valid),
    .sym_ready   (sym_ready),
    .sym_byte    (sym_byte),
    .sym_is_data (sym_is_data),
    .rx_ready    (rx_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_byte    (out_byte),
    .chan_valid  (chan_valid),
    .chan_ready  (chan_ready),
    .chan_addr   (chan_addr)
);

// File: tb/rle_stream_codec_tb_top.sv
`timescale 1ns/1ps
module rle_stream_codec_tb_top;

    typedef logic [8:0] sym_t;          // {is_data, byte}
    typedef sym_t       symq_t[$];
    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rle_en = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_ready;
    logic addr_valid = 1'b0;
    logic [6:0] addr_chan = '0;
    logic addr_ready;
    logic sym_valid, sym_is_data, sym_ready;
    logic [7:0] sym_byte;
    logic rx_valid, rx_is_data, rx_ready;
    logic [7:0] rx_byte;
    logic out_valid, out_ready;
    logic [7:0] out_byte;
    logic chan_valid, chan_ready;
    logic [6:0] chan_addr;

    logic loop_sel = 1'b0;
    logic bp_on = 1'b0;
    logic hold_out = 1'b0;
    logic tx_rdy = 1'b1;
    logic drv_rx_valid = 1'b0, drv_rx_is_data = 1'b0;
    logic [7:0] drv_rx_byte = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    symq_t sym_q;
    bq_t   out_q;
    bq_t   chan_q;

    assign rx_valid   = loop_sel ? sym_valid   : drv_rx_valid;
    assign rx_byte    = loop_sel ? sym_byte    : drv_rx_byte;
    assign rx_is_data = loop_sel ? sym_is_data : drv_rx_is_data;
    assign sym_ready  = loop_sel ? rx_ready    : tx_rdy;

    rle_stream_codec dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rle_en(cfg_rle_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .in_last(in_last),
        .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_chan(addr_chan),
        .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_byte(sym_byte), .sym_is_data(sym_is_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte), .rx_is_data(rx_is_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .chan_valid(chan_valid), .chan_ready(chan_ready), .chan_addr(chan_addr)
    );

    always #5 clk = ~clk;

    // Ready generation and handshake monitor, away from the rising edge
    always @(negedge clk) begin
        tx_rdy     = bp_on ? (($urandom % 4) != 0) : 1'b1;
        out_ready  = hold_out ? 1'b0 : (bp_on ? (($urandom % 4) != 0) : 1'b1);
        chan_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
        #2;
        if (sym_valid && sym_ready)   sym_q.push_back({sym_is_data, sym_byte});
        if (out_valid && out_ready)   out_q.push_back(out_byte);
        if (chan_valid && chan_ready) chan_q.push_back({1'b0, chan_addr});
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic symq_t encode(bq_t b, bit en);
        symq_t r;
        int i, j, len;
        i = 0;
        while (i < b.size()) begin
            if (!en) begin
                r.push_back({1'b1, b[i]});
                i++;
            end else begin
                j = i;
                while (j < b.size() && b[j] == b[i] && (j - i) < 128) j++;
                len = j - i;
                if (len >= 2) r.push_back({1'b0, 8'(len - 1)});
                r.push_back({1'b1, b[i]});
                i = j;
            end
        end
        return r;
    endfunction

    task automatic cmp_syms(symq_t exp, string req);
        bit ok;
        int act_v, exp_v;
        ok = (exp.size() == sym_q.size());
        act_v = sym_q.size();
        exp_v = exp.size();
        if (ok) begin
            for (int k = 0; k < exp.size(); k++) begin
                if (ok && exp[k] !== sym_q[k]) begin
                    ok = 1'b0;
                    act_v = int'(sym_q[k]);
                    exp_v = int'(exp[k]);
                end
            end
        end
        check(ok, req, "symbol stream", act_v, exp_v);
    endtask

    task automatic cmp_bytes(bq_t exp, bq_t act, string req, string what);
        bit ok;
        int act_v, exp_v;
        ok = (exp.size() == act.size());
        act_v = act.size();
        exp_v = exp.size();
        if (ok) begin
            for (int k = 0; k < exp.size(); k++) begin
                if (ok && exp[k] !== act[k]) begin
                    ok = 1'b0;
                    act_v = int'(act[k]);
                    exp_v = int'(exp[k]);
                end
            end
        end
        check(ok, req, what, act_v, exp_v);
    endtask

    task automatic send_byte(logic [7:0] b, logic last);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_last = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_pkt(bq_t b);
        for (int k = 0; k < b.size(); k++) send_byte(b[k], k == b.size() - 1);
    endtask

    task automatic send_addr(logic [6:0] a);
        @(negedge clk);
        addr_valid = 1'b1; addr_chan = a;
        #1;
        while (!addr_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 addr_valid = 1'b0;
    endtask

    task automatic send_rx(logic flag, logic [7:0] b);
        @(negedge clk);
        drv_rx_valid = 1'b1; drv_rx_is_data = flag; drv_rx_byte = b;
        #1;
        while (!rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 drv_rx_valid = 1'b0;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
        #3;
    endtask

    task automatic clear_q();
        sym_q.delete();
        out_q.delete();
        chan_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        report();
    end

    initial begin
        bq_t pkt, all_in;
        symq_t exp, all_sym;
        void'($urandom(32'd2024));

        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        check(!sym_valid && !out_valid && !chan_valid, "R1", "valids in reset", {sym_valid, out_valid, chan_valid}, 0);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check(!sym_valid && !out_valid && !chan_valid, "R1", "valids after reset", {sym_valid, out_valid, chan_valid}, 0);
        check(in_ready && addr_ready && rx_ready, "R1", "readies after reset", {in_ready, addr_ready, rx_ready}, 7);

        // R2 raw pass-through, bytes with bit 7 set stay data
        clear_q();
        cfg_rle_en = 1'b0;
        pkt = '{8'h11, 8'h11, 8'h85, 8'h11};
        send_pkt(pkt);
        settle(10);
        cmp_syms(encode(pkt, 1'b0), "R2");

        // R3 run of five
        clear_q();
        cfg_rle_en = 1'b1;
        pkt = '{8'h41, 8'h41, 8'h41, 8'h41, 8'h41};
        send_pkt(pkt);
        settle(10);
        exp = '{9'h004, 9'h141};
        cmp_syms(exp, "R3");

        // R4 single bytes between differing neighbours
        clear_q();
        pkt = '{8'h7E, 8'h80, 8'h80, 8'h7E};
        send_pkt(pkt);
        settle(10);
        exp = '{9'h17E, 9'h001, 9'h180, 9'h17E};
        cmp_syms(exp, "R4");

        // R5 run of 300 under backpressure: 128 + 128 + 44
        clear_q();
        bp_on = 1'b1;
        pkt.delete();
        repeat (300) pkt.push_back(8'h55);
        send_pkt(pkt);
        settle(40);
        exp = '{9'h07F, 9'h155, 9'h07F, 9'h155, 9'h02B, 9'h155};
        cmp_syms(exp, "R5");

        // R5 run of 129: trailing single copy has no count
        clear_q();
        pkt.delete();
        repeat (129) pkt.push_back(8'h0F);
        send_pkt(pkt);
        settle(40);
        exp = '{9'h07F, 9'h10F, 9'h10F};
        cmp_syms(exp, "R5");
        bp_on = 1'b0;

        // R6 packet boundary keeps runs apart
        clear_q();
        pkt = '{8'h09, 8'h09};
        send_pkt(pkt);
        pkt = '{8'h09, 8'h09, 8'h09};
        send_pkt(pkt);
        settle(10);
        exp = '{9'h001, 9'h109, 9'h002, 9'h109};
        cmp_syms(exp, "R6");

        // R7 address closes an open run
        clear_q();
        send_byte(8'hAA, 1'b0);
        send_byte(8'hAA, 1'b0);
        send_byte(8'hAA, 1'b0);
        send_addr(7'h05);
        send_byte(8'hBB, 1'b1);
        settle(10);
        exp = '{9'h002, 9'h1AA, 9'h085, 9'h1BB};
        cmp_syms(exp, "R7");

        // R7 address and byte offered in the same cycle
        clear_q();
        send_byte(8'h33, 1'b0);
        send_byte(8'h33, 1'b0);
        @(negedge clk);
        addr_valid = 1'b1; addr_chan = 7'h7F;
        in_valid = 1'b1; in_byte = 8'h44; in_last = 1'b1;
        #1;
        check(!in_ready, "R7", "in_ready with address pending", in_ready, 0);
        while (!addr_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 addr_valid = 1'b0;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 in_valid = 1'b0; in_last = 1'b0;
        settle(10);
        exp = '{9'h001, 9'h133, 9'h0FF, 9'h144};
        cmp_syms(exp, "R7");

        // R9 and R11: count 3 then data, expansion stalled
        clear_q();
        hold_out = 1'b1;
        send_rx(1'b0, 8'h03);
        send_rx(1'b1, 8'h5A);
        settle(2);
        check(out_valid && !rx_ready, "R11", "rx_ready during stalled expansion", {out_valid, rx_ready}, 2);
        hold_out = 1'b0;
        settle(10);
        pkt = '{8'h5A, 8'h5A, 8'h5A, 8'h5A};
        cmp_bytes(pkt, out_q, "R9", "expanded copies");

        // R9 data without count
        clear_q();
        send_rx(1'b1, 8'h10);
        settle(6);
        pkt = '{8'h10};
        cmp_bytes(pkt, out_q, "R9", "single copy");

        // R10 address discards pending count
        clear_q();
        send_rx(1'b0, 8'h06);
        send_rx(1'b0, 8'hAA);
        send_rx(1'b1, 8'h77);
        settle(8);
        pkt = '{8'h2A};
        cmp_bytes(pkt, chan_q, "R10", "channel address");
        pkt = '{8'h77};
        cmp_bytes(pkt, out_q, "R10", "copies after address");

        // Random loopback: R2 R3 R4 R5 R9 end to end
        clear_q();
        loop_sel = 1'b1;
        bp_on = 1'b1;
        all_in.delete();
        all_sym.delete();
        for (int p = 0; p < 40; p++) begin
            logic en_p;
            en_p = (($urandom % 4) != 0);
            pkt.delete();
            for (int s = 0; s < 1 + int'($urandom % 4); s++) begin
                logic [7:0] v;
                int len;
                case ($urandom % 4)
                    0: v = 8'h00;
                    1: v = 8'h80;
                    2: v = 8'h41;
                    default: v = 8'hFF;
                endcase
                len = (($urandom % 10) == 0) ? 130 + int'($urandom % 40) : 1 + int'($urandom % 4);
                repeat (len) pkt.push_back(v);
            end
            cfg_rle_en = en_p;
            send_pkt(pkt);
            exp = encode(pkt, en_p);
            foreach (exp[k]) all_sym.push_back(exp[k]);
            foreach (pkt[k]) all_in.push_back(pkt[k]);
        end
        settle(800);
        cmp_syms(all_sym, "R3");
        cmp_bytes(all_in, out_q, "R9", "loopback bytes");

        report();
    end

endmodule